// File: doc/BRIEF.md
# Amplifier Protection Fault Supervisor

This block is the protection state machine for a two-channel bridge audio output stage. It watches the shutdown control, a per-channel overcurrent flag, a per-channel DC-offset comparator flag, and the supply (under-voltage, over-voltage) and thermal-trip comparators. From these it decides, for every channel, whether the output bridge switches normally, floats at high impedance or is held low. It also drives an active-low open-drain fault indication.

The two latched faults clear in different ways. A DC-offset fault is set only after the comparator has stayed asserted for a long, uninterrupted hold time. Once set, it stays set until power-on reset. A short-circuit fault sets immediately on any overcurrent flag and clears when shutdown is pulled low. When the auto-recovery input is set, which models the fault pin being looped back to shutdown, a short-circuit fault releases itself after the same hold time and re-arms. Supply and thermal conditions only force the outputs low. They are never reported on the fault pin.

Both hold times are counted in ticks. One tick is `TICK_DIV` clock cycles, and the hold is `HOLD_TICKS` ticks, so a scaled timebase can stand in for the real 420 ms interval.

Top module: `amp_fault_supervisor`

## Requirements
- R1: A DC-offset fault sets only when one channel's DC comparator has stayed high for more than `HOLD_TICKS` ticks without a break, where one tick is `TICK_DIV` cycles. Any cycle with the comparator low restarts that channel's count from zero.
- R2: While a DC-offset fault is set, every channel is in high impedance and `fault_n_o` is 0.
- R3: A DC-offset fault is not cleared by taking `sd_n_i` low, by auto-recovery or by the comparator going low. Only `rst_n` clears it.
- R4: An overcurrent flag on any channel while `sd_n_i` is 1 sets the short-circuit latch at the next clock edge. The latch puts every channel in high impedance and drives `fault_n_o` to 0.
- R5: `sd_n_i` at 0 clears the short-circuit latch, and the latch cannot set while `sd_n_i` is 0.
- R6: With `auto_rec_i` at 1, the short-circuit latch releases once more than `HOLD_TICKS` ticks have passed since it set. If overcurrent is still present, it sets again one cycle later. With `auto_rec_i` at 0, the latch holds indefinitely.
- R7: With `sd_n_i` at 0 and no latched fault, every channel is in high impedance and `fault_n_o` is 1.
- R8: With `sd_n_i` at 1, no latched fault and any of `uv_i`, `ov_i` or `ot_i` at 1, every channel is held low and `fault_n_o` is 1.
- R9: The mode of channel c is on `mode_o[2c+1:2c]`, with 2'b00 for held low, 2'b01 for active and 2'b10 for high impedance. With no condition present, every channel is active. `mode_o` is registered and follows its inputs one cycle later.
- R10: Priority is a latched fault (high impedance) first, then shutdown (high impedance), then supply or thermal (held low), then active.
- R11: While `rst_n` is 0, every channel is in high impedance and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sd_n_i | input | 1 | Shutdown control; 1 = operate, 0 = mute |
| auto_rec_i | input | 1 | Auto-recovery enable (fault pin looped to shutdown) |
| oc_i | input | NCH | Per-channel overcurrent flags |
| dc_i | input | NCH | Per-channel DC-offset comparator flags |
| uv_i | input | 1 | Under-voltage comparator |
| ov_i | input | 1 | Over-voltage comparator |
| ot_i | input | 1 | Thermal trip comparator |
| mode_o | output | 2*NCH | Per-channel output-stage mode |
| fault_n_o | output | 1 | Fault indication, active low (0 = pull down) |

## Verification
Two cases can fall in the same cycle or overlap. The first is the auto-recovery release of the short-circuit latch while the overcurrent flag is still present. The bench holds overcurrent high across several release periods and judges that the fault pin is low in most cycles but rises briefly in at least one. The second is a DC-offset fault that sets while the short-circuit latch is already held. The bench sets the short latch with auto-recovery on, then holds the DC comparator high past its hold time. It then checks that after the short latch would have released, the fault pin stays low and every channel stays in high impedance.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;

  typedef enum logic [1:0] {
    OUT_LOW   = 2'b00,
    OUT_DRIVE = 2'b01,
    OUT_HIZ   = 2'b10
  } out_mode_e;

endpackage

// File: rtl/amp_tick_gen.sv
module amp_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap   = (cnt_q == DW'(TICK_DIV - 1));
      assign tick_o = wrap;

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/amp_dc_monitor.sv
module amp_dc_monitor #(
  parameter int NCH        = 2,
  parameter int HOLD_TICKS = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic [NCH-1:0] dc_i,
  output logic           dc_fault_o
);

  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic [NCH-1:0] hit;
  logic           fault_q, fault_d;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign cnt_en = tick_i & dc_i[c];
      assign hit[c] = cnt_en & (cnt_q == CW'(HOLD_TICKS));

      always_comb begin
        cnt_d = cnt_q;
        if (!dc_i[c])     cnt_d = '0;
        else if (hit[c])  cnt_d = cnt_q;
        else if (cnt_en)  cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      AST_DC_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HOLD_TICKS)); // R1
      AST_DC_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_i[c] |=> (cnt_q == '0)); // R1
    end
  endgenerate

  always_comb begin
    fault_d = fault_q | (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign dc_fault_o = fault_q;

  AST_DC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q); // R3

endmodule

// File: rtl/amp_short_latch.sv
module amp_short_latch #(
  parameter int NCH        = 2,
  parameter int HOLD_TICKS = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           sd_n_i,
  input  logic           auto_rec_i,
  input  logic [NCH-1:0] oc_i,
  output logic           sc_fault_o
);

  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic          latch_q, latch_d;
  logic [CW-1:0] tmr_q, tmr_d;
  logic          tmr_en, release_now;

  assign tmr_en      = latch_q & auto_rec_i & tick_i;
  assign release_now = tmr_en & (tmr_q == CW'(HOLD_TICKS));

  always_comb begin
    latch_d = latch_q;
    tmr_d   = tmr_q;
    if (!sd_n_i) begin
      latch_d = 1'b0;
      tmr_d   = '0;
    end else if (release_now) begin
      latch_d = 1'b0;
      tmr_d   = '0;
    end else if (!latch_q) begin
      latch_d = |oc_i;
      tmr_d   = '0;
    end else if (!auto_rec_i) begin
      tmr_d   = '0;
    end else if (tmr_en) begin
      tmr_d   = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      latch_q <= latch_d;
      tmr_q   <= tmr_d;
    end
  end

  assign sc_fault_o = latch_q;

  AST_SC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_n_i && (|oc_i) && !latch_q) |=> latch_q); // R4
  AST_SC_SD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n_i |=> !latch_q); // R5
  AST_SC_HOLDS_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && sd_n_i && !auto_rec_i) |=> latch_q); // R6
  AST_SC_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= CW'(HOLD_TICKS)); // R6

endmodule

// File: rtl/amp_mode_arbiter.sv
module amp_mode_arbiter
  import amp_sup_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latched_i,
  input  logic             sd_n_i,
  input  logic             supply_bad_i,
  output logic [2*NCH-1:0] mode_o
);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      out_mode_e mode_q, mode_d;

      always_comb begin
        if (latched_i)         mode_d = OUT_HIZ;
        else if (!sd_n_i)      mode_d = OUT_HIZ;
        else if (supply_bad_i) mode_d = OUT_LOW;
        else                   mode_d = OUT_DRIVE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= OUT_HIZ;
        else        mode_q <= mode_d;
      end

      assign mode_o[2*c +: 2] = mode_q;

      AST_HIZ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        latched_i |=> (mode_o[2*c +: 2] == 2'b10)); // R2
      AST_LOW_ON_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched_i && sd_n_i && supply_bad_i) |=> (mode_o[2*c +: 2] == 2'b00)); // R8
      AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[2*c +: 2] != 2'b11); // R9
    end
  endgenerate

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor #(
  parameter int NCH        = 2,
  parameter int TICK_DIV   = 4,
  parameter int HOLD_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd_n_i,
  input  logic             auto_rec_i,
  input  logic [NCH-1:0]   oc_i,
  input  logic [NCH-1:0]   dc_i,
  input  logic             uv_i,
  input  logic             ov_i,
  input  logic             ot_i,
  output logic [2*NCH-1:0] mode_o,
  output logic             fault_n_o
);

  logic tick;
  logic dc_fault, sc_fault, latched, supply_bad;

  amp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  amp_dc_monitor #(.NCH(NCH), .HOLD_TICKS(HOLD_TICKS)) u_dc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .dc_i       (dc_i),
    .dc_fault_o (dc_fault)
  );

  amp_short_latch #(.NCH(NCH), .HOLD_TICKS(HOLD_TICKS)) u_sc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .sd_n_i     (sd_n_i),
    .auto_rec_i (auto_rec_i),
    .oc_i       (oc_i),
    .sc_fault_o (sc_fault)
  );

  assign latched    = dc_fault | sc_fault;
  assign supply_bad = uv_i | ov_i | ot_i;

  amp_mode_arbiter #(.NCH(NCH)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .latched_i    (latched),
    .sd_n_i       (sd_n_i),
    .supply_bad_i (supply_bad),
    .mode_o       (mode_o)
  );

  assign fault_n_o = ~latched;

  AST_FAULT_PIN_DC: assert property (@(posedge clk) disable iff (!rst_n)
    dc_fault |-> !fault_n_o); // R2
  AST_SUPPLY_NOT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_fault && !sc_fault) |-> fault_n_o); // R8

endmodule

// File: tb/amp_fault_supervisor_tb.sv
module amp_fault_supervisor_tb;

  localparam int NCH  = 2;
  localparam int DIV  = 4;
  localparam int HOLD = 6;
  localparam logic [3:0] M_HIZ = 4'b1010;
  localparam logic [3:0] M_LOW = 4'b0000;
  localparam logic [3:0] M_ACT = 4'b0101;

  logic clk = 1'b0;
  logic rst_n;
  logic sd_n, auto_rec, uv, ov, ot;
  logic [NCH-1:0] oc, dc;
  logic [2*NCH-1:0] mode;
  logic fault_n;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  amp_fault_supervisor #(.NCH(NCH), .TICK_DIV(DIV), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .sd_n_i(sd_n), .auto_rec_i(auto_rec),
    .oc_i(oc), .dc_i(dc), .uv_i(uv), .ov_i(ov), .ot_i(ot),
    .mode_o(mode), .fault_n_o(fault_n)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [3:0] em, input logic ef);
    tests++;
    if (mode !== em || fault_n !== ef) begin
      fails++;
      $display("FAIL %s: mode=%b fault_n=%b expected mode=%b fault_n=%b",
               req, mode, fault_n, em, ef);
    end
  endtask

  task automatic por();
    rst_n = 1'b0;
    step(2);
  endtask

  function automatic logic [3:0] expect_mode(input logic latched, input logic s,
                                             input logic bad);
    if (latched) return M_HIZ;
    if (!s)      return M_HIZ;
    if (bad)     return M_LOW;
    return M_ACT;
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi_cnt;
    int lo_cnt;
    rst_n = 1'b0; sd_n = 1'b0; auto_rec = 1'b0; uv = 1'b0; ov = 1'b0; ot = 1'b0;
    oc = '0; dc = '0;
    step(2);
    chk("R11 reset state", M_HIZ, 1'b1);
    rst_n = 1'b1;
    step(2);
    chk("R7 shutdown mutes", M_HIZ, 1'b1);

    // sweep shutdown and supply/thermal combinations, no latched fault
    for (int v = 0; v < 16; v++) begin
      sd_n = v[3]; uv = v[2]; ov = v[1]; ot = v[0];
      step(2);
      chk("R7 R8 R9 R10 sweep", expect_mode(1'b0, v[3], |v[2:0]), 1'b1);
    end
    uv = 0; ov = 0; ot = 0; sd_n = 1;

    // short-circuit latch per channel, with supply sweep under the latch
    for (int c = 0; c < NCH; c++) begin
      oc[c] = 1'b1;
      step(1);
      oc = '0;
      step(1);
      chk("R4 overcurrent latches", M_HIZ, 1'b0);
      for (int v = 0; v < 8; v++) begin
        uv = v[2]; ov = v[1]; ot = v[0];
        step(2);
        chk("R10 fault over supply", M_HIZ, 1'b0);
      end
      uv = 0; ov = 0; ot = 0;
      sd_n = 1'b0;
      step(2);
      chk("R5 shutdown clears latch", M_HIZ, 1'b1);
      sd_n = 1'b1;
      step(2);
      chk("R9 active after clear", M_ACT, 1'b1);
    end

    // R5: no set while shutdown low
    sd_n = 0; oc = 2'b11;
    step(3);
    chk("R5 no set in shutdown", M_HIZ, 1'b1);
    oc = '0; sd_n = 1;
    step(2);
    chk("R5 no latch after shutdown", M_ACT, 1'b1);

    // R6: no auto-recovery holds indefinitely
    oc = 2'b01; step(1); oc = '0;
    step((HOLD + 4) * DIV);
    chk("R6 held without auto", M_HIZ, 1'b0);
    sd_n = 0; step(2); sd_n = 1; step(2);

    // R6: auto-recovery releases after the hold time
    auto_rec = 1;
    oc = 2'b10; step(1); oc = '0;
    step(HOLD * DIV - 1);
    chk("R6 not released early", M_HIZ, 1'b0);
    step(2 * DIV + 4);
    chk("R6 auto released", M_ACT, 1'b1);

    // R6: persistent overcurrent re-cycles the latch
    oc = 2'b01;
    hi_cnt = 0; lo_cnt = 0;
    for (int i = 0; i < 4 * (HOLD + 2) * DIV; i++) begin
      step(1);
      if (fault_n) hi_cnt++; else lo_cnt++;
    end
    tests++;
    if (hi_cnt == 0 || lo_cnt <= hi_cnt) begin
      fails++;
      $display("FAIL R6 recycle: high=%0d low=%0d expected high>0 and low>high",
               hi_cnt, lo_cnt);
    end
    oc = '0;
    step((HOLD + 3) * DIV);
    chk("R6 recovered after overcurrent gone", M_ACT, 1'b1);
    auto_rec = 0;

    // DC persistence per channel
    for (int c = 0; c < NCH; c++) begin
      dc[c] = 1'b1;
      step(HOLD * DIV - 1);
      chk("R1 no fault before hold", M_ACT, 1'b1);
      dc[c] = 1'b0;
      step(1);
      dc[c] = 1'b1;
      step(HOLD * DIV - 1);
      chk("R1 break restarts count", M_ACT, 1'b1);
      step(DIV + 3);
      chk("R1 R2 dc fault set", M_HIZ, 1'b0);
      dc = '0;
      sd_n = 0; step(3); sd_n = 1; step(3);
      chk("R3 survives shutdown", M_HIZ, 1'b0);
      auto_rec = 1;
      step((HOLD + 3) * DIV);
      chk("R3 survives auto-recovery", M_HIZ, 1'b0);
      auto_rec = 0;
      por();
      chk("R11 reset during fault", M_HIZ, 1'b1);
      rst_n = 1; step(2);
      chk("R3 cleared by reset", M_ACT, 1'b1);
    end

    // DC fault arriving while short latch held with auto-recovery
    auto_rec = 1;
    oc = 2'b01; step(1); oc = '0;
    dc = 2'b10;
    step((HOLD + 1) * DIV + 3);
    dc = '0;
    step((HOLD + 3) * DIV);
    chk("R2 R3 dc holds past short release", M_HIZ, 1'b0);
    uv = 1; step(2);
    chk("R10 dc over supply", M_HIZ, 1'b0);
    uv = 0; auto_rec = 0;
    por();
    rst_n = 1; step(2);
    chk("R9 clean after reset", M_ACT, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule